// File: doc/BRIEF.md
# Single-Channel Block Transfer DMA Engine

This engine copies a block of words from a device controller into memory so that the processor does not copy each word itself. Software loads a destination address and a word count, then writes a control word that starts the job and picks how the shared bus is held. For each word the engine waits for bus ownership, asks the device for a word, writes that word to memory in a bus cycle of its own, and waits for the device to acknowledge that the write is complete. It repeats this until the count reaches zero. It then raises one interrupt for the whole block.

Two ways of holding the bus are available. In cycle-stealing mode the engine gives the bus back after every word, so the processor can use it between words. In burst mode the engine keeps the bus from the first word to the last, which avoids paying for arbitration on every word. A start with an empty count finishes at once and touches no bus signal.

Top module: `dma_engine`

## Requirements
- R1: The address register (select 0) and the count register (select 1) take the written value when the engine is idle and read back through `cfg_rdata`; writes to either while busy are ignored.
- R2: A write to select 2 with bit 0 set and a nonzero count makes `bus_req` and the busy flag high on the next cycle; `dev_rd_req` is never raised before `bus_gnt`.
- R3: For each word the engine holds `dev_rd_req` until `dev_rd_valid`, then drives `mem_wr` for exactly one cycle with `mem_addr` equal to the current address and `mem_wdata` equal to the captured word, then waits for `dev_ack` and issues no new read before it.
- R4: Each `dev_ack` raises the address by DATA_W/8 and lowers the count by one.
- R5: The number of words written to memory equals the programmed count, at consecutive addresses, in the order the device supplied them.
- R6: `irq` (status bit 1, done) rises on the cycle after the final `dev_ack`, never while the bus is requested, and never per word.
- R7: `irq` stays high until a write to select 3 with bit 1 set; such a write with bit 1 clear leaves it high.
- R8: With control bit 1 clear (cycle stealing), `bus_req` falls for one cycle after every acknowledged word except the last, so it rises once per word.
- R9: With control bit 1 set (burst), `bus_req` rises once and stays high until the final acknowledge.
- R10: A start write while busy is ignored: the running block keeps its count, address and mode.
- R11: A start with a count of zero sets `irq` on the next cycle and raises no bus signal.
- R12: Select 3 reads busy in bit 0, done in bit 1 and the remaining count in bits CNT_W+1 down to 2.
- R13: After reset all outputs are low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Read data of the selected register |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| dev_rd_req | output | 1 | Read request to the device controller |
| dev_rd_valid | input | 1 | Device word is present on dev_rd_data |
| dev_rd_data | input | DATA_W | Word from the device |
| mem_wr | output | 1 | One-cycle memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address of the write |
| mem_wdata | output | DATA_W | Memory write data |
| dev_ack | input | 1 | Device acknowledge that the memory write finished |
| irq | output | 1 | Block-complete interrupt |

## Verification
A start write takes effect at the clock edge that samples it, so `bus_req` and the busy flag are checked at the falling edge just after that write; a zero-count start is checked for `irq` at the same point. The final `dev_ack` is registered by the engine, so `irq` is due one cycle after it, and the bench only reads the address, count and status registers once `irq` is seen high, at a falling edge. Per-word timing (read before grant, a read overlapping a pending acknowledge, `irq` while the bus is requested, `bus_req` rises per block) is counted every rising edge by the bench's device and arbiter model and compared once the block is done.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARB,
      ST_FETCH,
      ST_STORE,
      ST_WAITACK,
      ST_YIELD
   } seq_state_t;

   localparam logic [1:0] SEL_ADDR  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_CTRL  = 2'd2;
   localparam logic [1:0] SEL_STAT  = 2'd3;

   localparam int CTRL_GO_BIT    = 0;
   localparam int CTRL_BURST_BIT = 1;
   localparam int STAT_BUSY_BIT  = 0;
   localparam int STAT_DONE_BIT  = 1;
   localparam int STAT_CNT_LSB   = 2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
   import dma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 16,
   parameter bit ALLOW_BURST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              busy,
   input  logic              step,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_cnt,
   output logic              burst_mode,
   output logic              go,
   output logic              done
);
   localparam int               STEP_BYTES = DATA_W / 8;
   localparam logic [ADDR_W-1:0] ADDR_INC  = ADDR_W'(STEP_BYTES);
   localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

   logic wr_addr, wr_cnt, wr_ctrl, wr_stat;
   logic start_req, zero_go, last_step;

   assign wr_addr   = cfg_wr && (cfg_sel == SEL_ADDR)  && !busy;
   assign wr_cnt    = cfg_wr && (cfg_sel == SEL_COUNT) && !busy;
   assign wr_ctrl   = cfg_wr && (cfg_sel == SEL_CTRL)  && !busy;
   assign wr_stat   = cfg_wr && (cfg_sel == SEL_STAT);
   assign start_req = wr_ctrl && cfg_wdata[CTRL_GO_BIT];
   assign go        = start_req && (cur_cnt != '0);
   assign zero_go   = start_req && (cur_cnt == '0);
   assign last_step = step && (cur_cnt == CNT_ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         cur_cnt  <= '0;
      end else if (step) begin
         cur_addr <= cur_addr + ADDR_INC;
         cur_cnt  <= cur_cnt - CNT_ONE;
      end else begin
         if (wr_addr) cur_addr <= cfg_wdata[ADDR_W-1:0];
         if (wr_cnt)  cur_cnt  <= cfg_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                done <= 1'b0;
      else if (last_step || zero_go)             done <= 1'b1;
      else if (go)                               done <= 1'b0;
      else if (wr_stat && cfg_wdata[STAT_DONE_BIT]) done <= 1'b0;
   end

   generate
      if (ALLOW_BURST) begin : g_mode_reg
         logic burst_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       burst_q <= 1'b0;
            else if (wr_ctrl) burst_q <= cfg_wdata[CTRL_BURST_BIT];
         end
         assign burst_mode = burst_q;
      end else begin : g_mode_fixed
         assign burst_mode = 1'b0;
      end
   endgenerate

   always_comb begin
      cfg_rdata = '0;
      unique case (cfg_sel)
         SEL_ADDR:  cfg_rdata = DATA_W'(cur_addr);
         SEL_COUNT: cfg_rdata = DATA_W'(cur_cnt);
         SEL_CTRL:  cfg_rdata[CTRL_BURST_BIT] = burst_mode;
         SEL_STAT: begin
            cfg_rdata[STAT_BUSY_BIT] = busy;
            cfg_rdata[STAT_DONE_BIT] = done;
            cfg_rdata[STAT_CNT_LSB +: CNT_W] = cur_cnt;
         end
         default:   cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              burst_mode,
   input  logic              last_word,
   input  logic              bus_gnt,
   input  logic              dev_rd_valid,
   input  logic [DATA_W-1:0] dev_rd_data,
   input  logic              dev_ack,
   output logic              busy,
   output logic              bus_req,
   output logic              dev_rd_req,
   output logic              mem_wr,
   output logic [DATA_W-1:0] word_q,
   output logic              step
);
   seq_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (go) state_d = ST_ARB;
         ST_ARB:     if (bus_gnt) state_d = ST_FETCH;
         ST_FETCH:   if (dev_rd_valid) state_d = ST_STORE;
         ST_STORE:   state_d = ST_WAITACK;
         ST_WAITACK: begin
            if (dev_ack) begin
               if (last_word)       state_d = ST_IDLE;
               else if (burst_mode) state_d = ST_FETCH;
               else                 state_d = ST_YIELD;
            end
         end
         ST_YIELD:   state_d = ST_ARB;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         word_q <= '0;
      else if (state_q == ST_FETCH && dev_rd_valid)
         word_q <= dev_rd_data;
   end

   assign busy       = (state_q != ST_IDLE);
   assign bus_req    = (state_q == ST_ARB) || (state_q == ST_FETCH) ||
                       (state_q == ST_STORE) || (state_q == ST_WAITACK);
   assign dev_rd_req = (state_q == ST_FETCH);
   assign mem_wr     = (state_q == ST_STORE);
   assign step       = (state_q == ST_WAITACK) && dev_ack;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
   import dma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 16,
   parameter bit ALLOW_BURST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              dev_rd_req,
   input  logic              dev_rd_valid,
   input  logic [DATA_W-1:0] dev_rd_data,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              dev_ack,
   output logic              irq
);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
         $error("dma_engine: DATA_W must be a positive multiple of 8");
      end
      if (CNT_W < 1 || CNT_W + STAT_CNT_LSB > DATA_W) begin : g_bad_cnt_w
         $error("dma_engine: CNT_W must fit in the status word");
      end
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("dma_engine: ADDR_W must lie in 1..DATA_W");
      end
   endgenerate

   logic              busy, step, go, done, burst_mode;
   logic [CNT_W-1:0]  cur_cnt;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] word_q;

   dma_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .ALLOW_BURST(ALLOW_BURST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .step(step),
      .cur_addr(cur_addr), .cur_cnt(cur_cnt), .burst_mode(burst_mode),
      .go(go), .done(done)
   );

   dma_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .burst_mode(burst_mode),
      .last_word(cur_cnt == CNT_LAST), .bus_gnt(bus_gnt),
      .dev_rd_valid(dev_rd_valid), .dev_rd_data(dev_rd_data), .dev_ack(dev_ack),
      .busy(busy), .bus_req(bus_req), .dev_rd_req(dev_rd_req), .mem_wr(mem_wr),
      .word_q(word_q), .step(step)
   );

   assign mem_addr  = cur_addr;
   assign mem_wdata = word_q;
   assign irq       = done;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [1:0]        cfg_sel,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic              dev_rd_req,
   input logic              mem_wr,
   input logic              irq,
   input logic              busy,
   input logic              step,
   input logic              burst_mode,
   input logic [CNT_W-1:0]  cur_cnt
);
   logic start_wr, clear_wr;
   assign start_wr = cfg_wr && (cfg_sel == 2'd2) && cfg_wdata[0] && !busy;
   assign clear_wr = cfg_wr && (cfg_sel == 2'd3) && cfg_wdata[1];

   p_start_requests_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr && (cur_cnt != '0) |=> bus_req && busy);

   p_read_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rd_req |-> bus_gnt);

   p_store_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);

   p_count_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> cur_cnt == $past(cur_cnt) - CNT_W'(1));

   p_irq_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !busy && !bus_req);

   p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !clear_wr && !start_wr |=> irq);

   p_steal_yields_r8: assert property (@(posedge clk) disable iff (!rst_n)
      step && !burst_mode && (cur_cnt != CNT_W'(1)) |=> !bus_req);

   p_burst_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      step && burst_mode && (cur_cnt != CNT_W'(1)) |=> bus_req);

   p_zero_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr && (cur_cnt == '0) |=> irq && !bus_req);
endmodule

bind dma_engine dma_engine_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
   .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
   .dev_rd_req(dev_rd_req), .mem_wr(mem_wr), .irq(irq), .busy(busy),
   .step(step), .burst_mode(burst_mode), .cur_cnt(cur_cnt)
);

// File: tb/dma_engine_test.sv
module dma_engine_test;
   localparam int CLK_P   = 10;
   localparam int DW      = 32;
   localparam int AW      = 32;
   localparam int CW      = 16;
   localparam logic [31:0] PAT  = 32'hA500_0000;
   localparam logic [31:0] BASE = 32'h0000_1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [1:0]    cfg_sel = 2'd0;
   logic [DW-1:0] cfg_wdata = '0;
   logic [DW-1:0] cfg_rdata;
   logic          bus_req, dev_rd_req, mem_wr, irq;
   logic          bus_gnt = 1'b0, dev_rd_valid = 1'b0, dev_ack = 1'b0;
   logic [DW-1:0] dev_rd_data = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;

   int checks = 0;
   int errs = 0;

   // bench-side model state and monitor counters
   logic        seen = 1'b0;
   int          ack_wait = 0;
   int          rd_idx = 0;
   int          nwr = 0;
   int          req_rises = 0;
   int          rd_no_gnt = 0;
   int          rd_overlap = 0;
   int          irq_early = 0;
   logic        prev_req = 1'b0;
   logic [31:0] log_a [16];
   logic [31:0] log_d [16];

   always #(CLK_P/2) clk = ~clk;

   dma_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .ALLOW_BURST(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .dev_rd_req(dev_rd_req), .dev_rd_valid(dev_rd_valid),
      .dev_rd_data(dev_rd_data), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .dev_ack(dev_ack), .irq(irq)
   );

   // arbiter, device and memory model plus monitors, driven at the rising edge
   initial begin
      forever begin
         @(posedge clk);
         if (!rst_n) begin
            seen <= 1'b0; bus_gnt <= 1'b0; dev_rd_valid <= 1'b0; dev_ack <= 1'b0;
            ack_wait = 0;
         end else begin
            if (dev_rd_req && !bus_gnt) rd_no_gnt++;
            if (dev_rd_req && (ack_wait > 0 || dev_ack)) rd_overlap++;
            if (irq && bus_req) irq_early++;
            if (bus_req && !prev_req) req_rises++;
            prev_req = bus_req;
            seen    <= bus_req;
            bus_gnt <= bus_req && seen;
            dev_rd_valid <= dev_rd_req && !dev_rd_valid;
            if (dev_rd_req && !dev_rd_valid) dev_rd_data <= PAT + 32'(rd_idx);
            if (dev_rd_req && dev_rd_valid) rd_idx++;
            dev_ack <= (ack_wait == 1);
            if (ack_wait > 0) ack_wait--;
            if (mem_wr) begin
               if (nwr < 16) begin
                  log_a[nwr] = mem_addr;
                  log_d[nwr] = mem_wdata;
               end
               nwr++;
               ack_wait = 2;
            end
         end
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: got %h expected %h", rq, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_wdata = '0;
   endtask

   task automatic rd_reg(input logic [1:0] sel, output logic [31:0] val);
      cfg_sel = sel;
      #1 val = cfg_rdata;
   endtask

   task automatic clr_mon();
      nwr = 0; rd_idx = 0; req_rises = 0; rd_no_gnt = 0; rd_overlap = 0; irq_early = 0;
   endtask

   task automatic wait_irq(input int limit);
      for (int i = 0; i < limit && irq !== 1'b1; i++) @(negedge clk);
   endtask

   task automatic check_log(input string rq, input int n, input logic [31:0] base);
      for (int i = 0; i < n; i++) begin
         chk({rq, " addr"}, log_a[i], base + 32'(4 * i));
         chk({rq, " data"}, log_d[i], PAT + 32'(i));
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R13 bus_req", 32'(bus_req), 0);
      chk("R13 dev_rd_req", 32'(dev_rd_req), 0);
      chk("R13 mem_wr", 32'(mem_wr), 0);
      chk("R13 irq", 32'(irq), 0);
      rd_reg(2'd3, v); chk("R13 status", v, 0);
      rd_reg(2'd0, v); chk("R13 addr", v, 0);
   endtask

   task automatic t_program();
      logic [31:0] v;
      wr_reg(2'd0, BASE);
      wr_reg(2'd1, 32'd5);
      rd_reg(2'd0, v); chk("R1 addr readback", v, BASE);
      rd_reg(2'd1, v); chk("R1 count readback", v, 32'd5);
      rd_reg(2'd3, v); chk("R12 status count field", v, 32'd5 << 2);
   endtask

   task automatic t_burst();
      logic [31:0] v;
      clr_mon();
      wr_reg(2'd2, 32'h3);
      chk("R2 bus_req after start", 32'(bus_req), 1);
      rd_reg(2'd3, v); chk("R2 busy after start", 32'(v[0]), 1);
      chk("R6 irq not yet", 32'(irq), 0);
      wait_irq(200);
      chk("R6 irq raised", 32'(irq), 1);
      chk("R5 word count", 32'(nwr), 5);
      check_log("R5 burst", 5, BASE);
      chk("R9 single bus request", 32'(req_rises), 1);
      chk("R2 read before grant", 32'(rd_no_gnt), 0);
      chk("R3 read overlaps ack", 32'(rd_overlap), 0);
      chk("R6 irq while bus held", 32'(irq_early), 0);
      rd_reg(2'd0, v); chk("R4 final address", v, BASE + 32'd20);
      rd_reg(2'd1, v); chk("R4 final count", v, 0);
      rd_reg(2'd3, v); chk("R12 status done idle", v, 32'h2);
   endtask

   task automatic t_irq_clear();
      repeat (5) @(negedge clk);
      chk("R7 irq holds", 32'(irq), 1);
      wr_reg(2'd3, 32'h1);
      chk("R7 write without done bit", 32'(irq), 1);
      wr_reg(2'd3, 32'h2);
      chk("R7 cleared", 32'(irq), 0);
   endtask

   task automatic t_steal();
      clr_mon();
      wr_reg(2'd0, BASE + 32'h100);
      wr_reg(2'd1, 32'd4);
      wr_reg(2'd2, 32'h1);
      wait_irq(300);
      chk("R8 irq raised", 32'(irq), 1);
      chk("R8 word count", 32'(nwr), 4);
      chk("R8 request per word", 32'(req_rises), 4);
      chk("R3 read overlaps ack", 32'(rd_overlap), 0);
      chk("R2 read before grant", 32'(rd_no_gnt), 0);
      check_log("R3 steal", 4, BASE + 32'h100);
      wr_reg(2'd3, 32'h2);
   endtask

   task automatic t_busy_write();
      logic [31:0] v;
      clr_mon();
      wr_reg(2'd0, BASE);
      wr_reg(2'd1, 32'd6);
      wr_reg(2'd2, 32'h3);
      repeat (3) @(negedge clk);
      wr_reg(2'd0, 32'h0);
      wr_reg(2'd1, 32'd2);
      wr_reg(2'd2, 32'h1);
      rd_reg(2'd3, v);
      chk("R12 busy during block", 32'(v[0]), 1);
      chk("R10 count kept", 32'(v[2 +: CW] > 16'd2), 1);
      rd_reg(2'd2, v); chk("R10 mode kept", v, 32'h2);
      wait_irq(300);
      chk("R10 words moved", 32'(nwr), 6);
      chk("R10 burst kept", 32'(req_rises), 1);
      check_log("R1 busy write ignored", 6, BASE);
      rd_reg(2'd0, v); chk("R4 address", v, BASE + 32'd24);
      wr_reg(2'd3, 32'h2);
   endtask

   task automatic t_zero();
      logic [31:0] v;
      clr_mon();
      wr_reg(2'd1, 32'd0);
      wr_reg(2'd2, 32'h1);
      chk("R11 irq next cycle", 32'(irq), 1);
      chk("R11 no bus_req", 32'(bus_req), 0);
      repeat (4) @(negedge clk);
      chk("R11 no bus activity", 32'(req_rises + nwr), 0);
      rd_reg(2'd3, v); chk("R11 status", v, 32'h2);
      wr_reg(2'd3, 32'h2);
   endtask

   initial begin
      #(CLK_P * 100000);
      checks++; errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program();
      t_burst();
      t_irq_clear();
      t_steal();
      t_busy_write();
      t_zero();
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - errs, checks);
      $finish;
   end
endmodule